// File: doc/BRIEF.md
# Conversion Result Store with Threshold Compare

This block sits between an A/D conversion engine and a register bus. The engine hands it one unsigned 10-bit result at a time, tagged with the result's position in the current conversion sequence (its slot, 0 to 7). The slot is the conversion number within the sequence, not the analog channel. Each slot owns one 16-bit register.

When a slot's compare-enable input bit is clear, the formatted result is written into the slot register. When the bit is set, the slot register holds a software-written threshold and the result is thrown away after it has been compared. The compare relation is picked per slot by an operator register: strictly greater than, or less than or equal. Each conversion sets a per-slot done flag. A relation that holds sets a per-slot match flag. Software clears the flags by writing 1s to them.

A justification input places the 10-bit result either at the top or at the bottom of the 16-bit word. Thresholds must be written in the same format, and the comparison is made on the two 16-bit forms. Any bus write to the operator register raises a one-cycle abort pulse towards the engine.

Top module: `adc_result_store`

## Requirements
- R1: After reset, every bus-visible register reads 0 and `abort_o` is low.
- R2: Bus addresses map as follows. 0x0 is the operator register, 0x1 is the flag register, and 0x8+n is the register of slot n. Reads are combinational on `bus_addr_i`. Writes take effect at the clock edge when `bus_sel_i` and `bus_we_i` are high. Every other address reads 0.
- R3: For a slot in store mode with `justify_left_i`=0, a conversion writes the result into bits 9:0 of the slot register, and bits 15:10 become 0.
- R4: For a slot in store mode with `justify_left_i`=1, a conversion writes the result into bits 15:6 of the slot register, and bits 5:0 become 0.
- R5: For a slot in compare mode (`cmp_en_i[n]`=1), a conversion leaves the slot register unchanged, so it keeps its threshold.
- R6: With operator bit n = 1, a compare-mode conversion sets match flag n only if the justified result is strictly greater than the threshold. A result equal to the threshold sets no flag.
- R7: With operator bit n = 0, a compare-mode conversion sets match flag n if the justified result is less than or equal to the threshold.
- R8: Every conversion on slot n sets done flag n, whatever the slot's mode. In the flag register, bit 8+n is done flag n and bit n is match flag n.
- R9: Writing 1 to a flag bit clears that bit, and writing 0 leaves it unchanged. A flag being set in the same cycle as a clear stays set.
- R10: A bus write to address 0x0 drives `abort_o` high for exactly the next cycle. A bus write to any other address does not.
- R11: Bits 15:8 of the operator register always read 0. Bits 7:0 hold the written value.
- R12: In store mode, a conversion overwrites any value that software wrote to the slot. When a bus write to the same slot lands in the same cycle, the conversion wins.
- R13: A conversion affects only the register and flags of the slot given on `conv_slot_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_valid_i | input | 1 | A conversion result is present this cycle |
| conv_slot_i | input | 3 | Conversion number (slot) of the result |
| conv_data_i | input | 10 | Unsigned conversion result |
| cmp_en_i | input | 8 | Per-slot compare enable (1 = compare mode) |
| justify_left_i | input | 1 | 1 = left-justified, 0 = right-justified |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus write enable |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational) |
| abort_o | output | 1 | Sequence abort pulse to the conversion engine |

## Verification
The bench aims at the equal-to-threshold boundary under both operators. A design that used `>=`, or `<`, would show a match flag one case off. It makes a flag clear and a done flag set collide in one cycle, and a software write and a conversion store collide in one cycle. A wrong priority would either lose the new flag or keep the software value. It also writes all ones to the operator register and checks abort pulses after operator writes and after writes elsewhere. A design that stored the upper byte, or aborted on any write, would show it.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef enum logic [1:0] {
    SEL_OP   = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_SLOT = 2'd2,
    SEL_NONE = 2'd3
  } ars_sel_e;

  localparam int unsigned OP_ADDR   = 0;
  localparam int unsigned FLAG_ADDR = 1;
endpackage

// File: rtl/ars_justify.sv
module ars_justify #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned REG_W = 16
) (
  input  logic [RES_W-1:0] data_i,
  input  logic             left_i,
  output logic [REG_W-1:0] data_o
);
  localparam int unsigned PAD = REG_W - RES_W;

  generate
    if (PAD == 0) begin : g_nopad
      assign data_o = data_i;
    end else begin : g_pad
      assign data_o = left_i ? {data_i, {PAD{1'b0}}} : {{PAD{1'b0}}, data_i};
    end
  endgenerate
endmodule

// File: rtl/ars_slot.sv
module ars_slot #(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             cmp_en_i,
  input  logic             cmp_gt_i,
  input  logic [REG_W-1:0] res_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] value_o,
  output logic             match_o
);
  logic [REG_W-1:0] value_q;
  logic             above;

  always_comb begin
    above   = res_i > value_q;
    match_o = hit_i & cmp_en_i & (cmp_gt_i ? above : ~above);
  end

  // a store from the engine beats a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 value_q <= '0;
    else if (hit_i && !cmp_en_i) value_q <= res_i;
    else if (wr_i)               value_q <= wdata_i;
  end

  assign value_o = value_q;
endmodule

// File: rtl/ars_flags.sv
module ars_flags #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] clr;

  assign clr = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RES_W     = 10,
  parameter int unsigned REG_W     = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W   = IDX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 conv_valid_i,
  input  logic [IDX_W-1:0]     conv_slot_i,
  input  logic [RES_W-1:0]     conv_data_i,
  input  logic [NUM_SLOTS-1:0] cmp_en_i,
  input  logic                 justify_left_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     bus_rdata_o,
  output logic                 abort_o
);
  import ars_pkg::*;

  localparam int unsigned FLAG_W = 2 * NUM_SLOTS;

  ars_sel_e                            sel;
  logic                                wr;
  logic [IDX_W-1:0]                    idx;
  logic [REG_W-1:0]                    res_just;
  logic [NUM_SLOTS-1:0]                op_q;
  logic                                abort_q;
  logic [NUM_SLOTS-1:0][REG_W-1:0]     slot_vals;
  logic [NUM_SLOTS-1:0]                match;
  logic [NUM_SLOTS-1:0]                done;
  logic [FLAG_W-1:0]                   flags;

  assign wr  = bus_sel_i & bus_we_i;
  assign idx = bus_addr_i[IDX_W-1:0];

  always_comb begin
    if (bus_addr_i[ADDR_W-1])                   sel = SEL_SLOT;
    else if (bus_addr_i == ADDR_W'(OP_ADDR))    sel = SEL_OP;
    else if (bus_addr_i == ADDR_W'(FLAG_ADDR))  sel = SEL_FLAG;
    else                                        sel = SEL_NONE;
  end

  ars_justify #(.RES_W(RES_W), .REG_W(REG_W)) u_just (
    .data_i (conv_data_i),
    .left_i (justify_left_i),
    .data_o (res_just)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= wr && (sel == SEL_OP);
      if (wr && (sel == SEL_OP)) op_q <= bus_wdata_i[NUM_SLOTS-1:0];
    end
  end

  generate
    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
      assign done[n] = conv_valid_i && (conv_slot_i == IDX_W'(n));
      ars_slot #(.REG_W(REG_W)) u_slot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hit_i    (done[n]),
        .cmp_en_i (cmp_en_i[n]),
        .cmp_gt_i (op_q[n]),
        .res_i    (res_just),
        .wr_i     (wr && (sel == SEL_SLOT) && (idx == IDX_W'(n))),
        .wdata_i  (bus_wdata_i),
        .value_o  (slot_vals[n]),
        .match_o  (match[n])
      );
    end
  endgenerate

  ars_flags #(.W(FLAG_W)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      ({done, match}),
    .clr_wr_i   (wr && (sel == SEL_FLAG)),
    .clr_mask_i (bus_wdata_i[FLAG_W-1:0]),
    .flags_o    (flags)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (sel)
      SEL_OP:   bus_rdata_o = REG_W'(op_q);
      SEL_FLAG: bus_rdata_o = REG_W'(flags);
      SEL_SLOT: bus_rdata_o = slot_vals[idx];
      default:  bus_rdata_o = '0;
    endcase
  end

  assign abort_o = abort_q;
endmodule

// File: rtl/ars_checker.sv
module ars_checker #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RES_W     = 10,
  parameter int unsigned REG_W     = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W   = IDX_W + 1,
  localparam int unsigned PAD      = REG_W - RES_W
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             conv_valid_i,
  input logic [IDX_W-1:0]                 conv_slot_i,
  input logic [NUM_SLOTS-1:0]             cmp_en_i,
  input logic                             justify_left_i,
  input logic                             bus_sel_i,
  input logic                             bus_we_i,
  input logic [ADDR_W-1:0]                bus_addr_i,
  input logic [REG_W-1:0]                 bus_rdata_o,
  input logic                             abort_o,
  input logic [NUM_SLOTS-1:0][REG_W-1:0]  slot_vals,
  input logic [2*NUM_SLOTS-1:0]           flags
);
  logic op_wr, slot_wr_same;
  assign op_wr        = bus_sel_i && bus_we_i && (bus_addr_i == '0);
  assign slot_wr_same = bus_sel_i && bus_we_i && bus_addr_i[ADDR_W-1] &&
                        (bus_addr_i[IDX_W-1:0] == conv_slot_i);

  a_r10_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_wr |=> abort_o);

  a_r10_no_spurious_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_wr |=> !abort_o);

  a_r11_op_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == '0) |-> (bus_rdata_o[REG_W-1:NUM_SLOTS] == '0));

  a_r8_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_valid_i |=> flags[NUM_SLOTS + $past(conv_slot_i)]);

  a_r5_threshold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_valid_i && cmp_en_i[conv_slot_i] && !slot_wr_same)
    |=> (slot_vals[$past(conv_slot_i)] == $past(slot_vals[conv_slot_i])));

  a_r4_left_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_valid_i && !cmp_en_i[conv_slot_i] && justify_left_i)
    |=> (slot_vals[$past(conv_slot_i)][PAD-1:0] == '0));
endmodule

bind adc_result_store ars_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .RES_W     (RES_W),
  .REG_W     (REG_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .conv_valid_i   (conv_valid_i),
  .conv_slot_i    (conv_slot_i),
  .cmp_en_i       (cmp_en_i),
  .justify_left_i (justify_left_i),
  .bus_sel_i      (bus_sel_i),
  .bus_we_i       (bus_we_i),
  .bus_addr_i     (bus_addr_i),
  .bus_rdata_o    (bus_rdata_o),
  .abort_o        (abort_o),
  .slot_vals      (slot_vals),
  .flags          (flags)
);

// File: tb/sim_adc_result_store.sv
`timescale 1ns/1ps
module sim_adc_result_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_valid = 1'b0;
  logic [2:0]  conv_slot = '0;
  logic [9:0]  conv_data = '0;
  logic [7:0]  cmp_en = '0;
  logic        just_left = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        abort;

  always #2.5 clk = ~clk;

  adc_result_store u0 (
    .clk_i(clk), .rst_ni(rst_n), .conv_valid_i(conv_valid), .conv_slot_i(conv_slot),
    .conv_data_i(conv_data), .cmp_en_i(cmp_en), .justify_left_i(just_left),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .abort_o(abort)
  );

  typedef struct {
    bit          is_abort;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  bit    mon_en = 1'b0;
  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;

  // monitor: pops one expectation per checked cycle, compares away from the edge
  always @(negedge clk) begin
    if (mon_en && q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = it.is_abort ? {15'd0, abort} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle_bus();
    conv_valid = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; mon_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    idle_bus();
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic conv(input logic [2:0] s, input logic [9:0] d);
    @(posedge clk); #1;
    idle_bus();
    conv_valid = 1'b1; conv_slot = s; conv_data = d;
  endtask

  task automatic conv_wr(input logic [2:0] s, input logic [9:0] d,
                         input logic [3:0] a, input logic [15:0] w);
    @(posedge clk); #1;
    idle_bus();
    conv_valid = 1'b1; conv_slot = s; conv_data = d;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = w;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    idle_bus();
    bus_addr = a;
    it.is_abort = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    mon_en = 1'b1;
  endtask

  task automatic chk_abort(input bit e, input string tag);
    item_t it;
    @(posedge clk); #1;
    idle_bus();
    it.is_abort = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
    q.push_back(it);
    mon_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_abort(1'b0, "R1 abort low after reset");
    rd(4'h0, 16'h0000, "R1 operator reg reset");
    rd(4'h1, 16'h0000, "R1 flag reg reset");
    rd(4'h8, 16'h0000, "R1 slot0 reset");
    rd(4'h3, 16'h0000, "R2 unmapped address reads 0");

    // store mode, right-justified, overwrites software value
    wr(4'hB, 16'hFFFF);
    rd(4'hB, 16'hFFFF, "R2 slot3 software write");
    conv(3'd3, 10'h2AB);
    rd(4'hB, 16'h02AB, "R3 R12 right-justified store");
    rd(4'h1, 16'h0800, "R8 done flag slot3");

    // left-justified
    just_left = 1'b1;
    conv(3'd5, 10'h3FF);
    rd(4'hD, 16'hFFC0, "R4 left-justified store");
    rd(4'hC, 16'h0000, "R13 neighbour slot4 untouched");
    rd(4'hB, 16'h02AB, "R13 slot3 untouched");
    just_left = 1'b0;

    // compare mode, operator greater-than on slot0
    cmp_en = 8'h01;
    wr(4'h0, 16'h0001);
    chk_abort(1'b1, "R10 abort after operator write");
    chk_abort(1'b0, "R10 abort lasts one cycle");
    wr(4'h8, 16'h0100);
    chk_abort(1'b0, "R10 no abort on slot write");
    conv(3'd0, 10'h100);
    rd(4'h8, 16'h0100, "R5 threshold kept");
    rd(4'h1, 16'h2900, "R6 equal gives no match under greater-than");
    conv(3'd0, 10'h101);
    rd(4'h1, 16'h2901, "R6 greater sets match");
    rd(4'h8, 16'h0100, "R5 threshold kept after match");
    wr(4'h1, 16'h2901);
    rd(4'h1, 16'h0000, "R9 write-one clears");

    // operator less-or-equal
    wr(4'h0, 16'h0000);
    conv(3'd0, 10'h100);
    rd(4'h1, 16'h0101, "R7 equal sets match under less-or-equal");
    wr(4'h1, 16'h0000);
    rd(4'h1, 16'h0101, "R9 writing zeros keeps flags");
    wr(4'h1, 16'hFFFF);
    conv(3'd0, 10'h101);
    rd(4'h1, 16'h0100, "R7 greater gives no match under less-or-equal");

    // set beats same-cycle clear
    conv_wr(3'd1, 10'h011, 4'h1, 16'hFFFF);
    rd(4'h1, 16'h0200, "R9 set wins over same-cycle clear");
    rd(4'h9, 16'h0011, "R3 slot1 store");

    // store beats same-cycle software write
    conv_wr(3'd2, 10'h055, 4'hA, 16'h1234);
    rd(4'hA, 16'h0055, "R12 conversion wins over bus write");

    // operator upper byte
    wr(4'h0, 16'hFFFF);
    rd(4'h0, 16'h00FF, "R11 upper byte reads zero");
    wr(4'hF, 16'h0F0F);
    chk_abort(1'b0, "R10 no abort on slot7 write");
    rd(4'hF, 16'h0F0F, "R2 slot7 read back");

    @(posedge clk); #1;
    idle_bus();
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule